// File: doc/BRIEF.md
# Control-Register Dependency Scoreboard

This block lets instructions that depend on non-renamed control registers keep flowing instead of draining the pipeline for every control-register write. It keeps one pending-write flag per control register. When an instruction is decoded, the block looks at which control registers it reads and at the stage where each of those reads happens. It then gives one of three answers in the same cycle. The instruction may run freely. The instruction may run only up to a given stop stage. Or decode must stall.

A decoded write to a register that has no write in flight is accepted, and that register is marked pending. A second write to a register that is still pending is a write-after-write case and stalls at decode. Control-register writers execute only at the head of the window, so write-after-read hazards cannot occur and readers are never tracked. When a writer retires, its flag clears and a release pulse for that register goes out in the same cycle. A flush that removes a pending writer clears its flag without a release pulse, because the dependent instructions are flushed with it.

Top module: `creg_scoreboard`

## Requirements
- R1: After reset no register is pending. Every decoded read comes back unrestricted, with `dec_limited` = 0 and `dec_stop_stage` = 15 (the "no stop" code).
- R2: A decoded write (`dec_valid`=1, `dec_wr_en`=1) to a register that is not pending causes no stall, and that register is pending from the next cycle on.
- R3: A decoded read of a pending register gives `dec_limited` = 1, and `dec_stop_stage` equals that register's read stage. The read stage of register i is the 4-bit field `dec_rd_stage[4i+3:4i]`, and bit i of `dec_rd_mask` selects register i.
- R4: An instruction that reads only non-pending registers gives `dec_limited` = 0 and `dec_stop_stage` = 15, even while other registers are pending.
- R5: A decoded write to a register that is already pending asserts `dec_stall`. While stalled, `dec_limited` = 0, `dec_stop_stage` = 15, and the instruction leaves the pending state unchanged.
- R6: If several pending registers are read, `dec_stop_stage` is the smallest of their read stages.
- R7: Retiring a pending register (`rt_valid`, `rt_idx`) sets bit `rt_idx` of `rel_mask` in that same cycle, and the register is no longer pending from the next cycle on.
- R8: A decode in the same cycle as a retire or flush of a register treats that register as not pending.
- R9: A flush (`flush_valid`, with `flush_mask` bit i standing for register i) clears the pending flags it names and produces no `rel_mask` bit.
- R10: Retiring a register that is not pending produces no `rel_mask` bit and changes no state.
- R11: A write accepted at decode in the same cycle as a retire or flush of the same register leaves that register pending afterwards.
- R12: With `dec_valid` = 0 the block never stalls, never restricts, and sets no pending flag, whatever `dec_wr_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_rd_mask | input | 8 | Control registers the instruction reads |
| dec_rd_stage | input | 32 | 4-bit read-stage index for each register |
| dec_wr_en | input | 1 | The instruction writes a control register |
| dec_wr_idx | input | 3 | Index of the register being written |
| rt_valid | input | 1 | A control-register writer retires |
| rt_idx | input | 3 | Register written by the retiring writer |
| flush_valid | input | 1 | Flush event |
| flush_mask | input | 8 | Registers whose pending writers are flushed |
| dec_stall | output | 1 | Hold the instruction at decode |
| dec_limited | output | 1 | The instruction must stop at dec_stop_stage |
| dec_stop_stage | output | 4 | Stage at which to hold; 15 means no stop |
| rel_mask | output | 8 | Registers whose held consumers are released this cycle |

## Verification
The hardest cases to reach are collisions within a single cycle. These are a decode landing in the same cycle as a retire or flush of the register it reads or writes, and a retire naming a register that is not pending. In each of them the answer depends on the order in which set, clear and lookup take effect. The stimulus sets up pending writers on chosen registers. It then issues decode, retire and flush together in one cycle, and reads the pending state back through later decoded reads. Reads with several hazards use distinct stage values, so that picking the wrong minimum shows up.

// File: rtl/creg_sb_pkg.sv
package creg_sb_pkg;
  localparam int unsigned CSB_NREG  = 8;
  localparam int unsigned CSB_STG_W = 4;
endpackage

// File: rtl/creg_sb_slots.sv
module creg_sb_slots #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic            rt_valid,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic            flush_valid,
  input  logic [NREG-1:0] flush_mask,
  output logic [NREG-1:0] pend_q,
  output logic [NREG-1:0] pend_eff,
  output logic [NREG-1:0] rel_mask
);
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic rt_hit;
    logic clr;
    logic set;
    logic en;
    logic nxt;

    always_comb begin
      rt_hit      = rt_valid && (rt_idx == IDX_W'(g));
      clr         = rt_hit || (flush_valid && flush_mask[g]);
      set         = set_en && (set_idx == IDX_W'(g));
      en          = set || clr;
      nxt         = set;
      pend_eff[g] = pend_q[g] && !clr;
      rel_mask[g] = pend_q[g] && rt_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= 1'b0;
      end else if (en) begin
        pend_q[g] <= nxt;
      end
    end
  end
endmodule

// File: rtl/creg_sb_hazard.sv
module creg_sb_hazard #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned STG_W = 4
) (
  input  logic [NREG-1:0]       rd_mask,
  input  logic [NREG*STG_W-1:0] rd_stage,
  input  logic [NREG-1:0]       pend_eff,
  output logic                  hit,
  output logic [STG_W-1:0]      min_stage
);
  always_comb begin
    hit       = 1'b0;
    min_stage = {STG_W{1'b1}};
    for (int i = 0; i < NREG; i++) begin
      if (rd_mask[i] && pend_eff[i]) begin
        hit = 1'b1;
        if (rd_stage[i*STG_W +: STG_W] < min_stage) begin
          min_stage = rd_stage[i*STG_W +: STG_W];
        end
      end
    end
  end
endmodule

// File: rtl/creg_scoreboard.sv
module creg_scoreboard #(
  parameter int unsigned NREG  = creg_sb_pkg::CSB_NREG,
  parameter int unsigned STG_W = creg_sb_pkg::CSB_STG_W,
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dec_valid,
  input  logic [NREG-1:0]       dec_rd_mask,
  input  logic [NREG*STG_W-1:0] dec_rd_stage,
  input  logic                  dec_wr_en,
  input  logic [IDX_W-1:0]      dec_wr_idx,
  input  logic                  rt_valid,
  input  logic [IDX_W-1:0]      rt_idx,
  input  logic                  flush_valid,
  input  logic [NREG-1:0]       flush_mask,
  output logic                  dec_stall,
  output logic                  dec_limited,
  output logic [STG_W-1:0]      dec_stop_stage,
  output logic [NREG-1:0]       rel_mask
);
  localparam logic [STG_W-1:0] STG_FREE = {STG_W{1'b1}};

  logic [NREG-1:0]  pend_q;
  logic [NREG-1:0]  pend_eff;
  logic             set_en;
  logic             haz_hit;
  logic [STG_W-1:0] haz_stage;

  creg_sb_slots #(.NREG(NREG), .IDX_W(IDX_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (set_en),
    .set_idx    (dec_wr_idx),
    .rt_valid   (rt_valid),
    .rt_idx     (rt_idx),
    .flush_valid(flush_valid),
    .flush_mask (flush_mask),
    .pend_q     (pend_q),
    .pend_eff   (pend_eff),
    .rel_mask   (rel_mask)
  );

  creg_sb_hazard #(.NREG(NREG), .STG_W(STG_W)) u_haz (
    .rd_mask  (dec_rd_mask),
    .rd_stage (dec_rd_stage),
    .pend_eff (pend_eff),
    .hit      (haz_hit),
    .min_stage(haz_stage)
  );

  always_comb begin
    dec_stall      = dec_valid && dec_wr_en && pend_eff[dec_wr_idx];
    set_en         = dec_valid && dec_wr_en && !dec_stall;
    dec_limited    = dec_valid && !dec_stall && haz_hit;
    dec_stop_stage = dec_limited ? haz_stage : STG_FREE;
  end
endmodule

// File: rtl/creg_scoreboard_chk.sv
module creg_scoreboard_chk #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned STG_W = 4,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dec_valid,
  input logic             dec_wr_en,
  input logic [IDX_W-1:0] dec_wr_idx,
  input logic             rt_valid,
  input logic             flush_valid,
  input logic             dec_stall,
  input logic             dec_limited,
  input logic [STG_W-1:0] dec_stop_stage,
  input logic [NREG-1:0]  rel_mask,
  input logic [NREG-1:0]  pend_q
);
  AST_STALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> (dec_valid && dec_wr_en)); // R5
  AST_STALL_UNRESTRICTED: assert property (@(posedge clk) disable iff (!rst_n)
    dec_stall |-> (!dec_limited && dec_stop_stage == {STG_W{1'b1}})); // R5
  AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_wr_en && !dec_stall) |=> pend_q[$past(dec_wr_idx)]); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!dec_stall && !dec_limited)); // R12
  AST_REL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_mask)); // R7
  AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_mask && !(dec_valid && dec_wr_en)) |=> ((pend_q & $past(rel_mask)) == '0)); // R7
  AST_FLUSH_NO_REL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !rt_valid) |-> (rel_mask == '0)); // R9
endmodule

bind creg_scoreboard creg_scoreboard_chk #(.NREG(NREG), .STG_W(STG_W), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dec_valid     (dec_valid),
  .dec_wr_en     (dec_wr_en),
  .dec_wr_idx    (dec_wr_idx),
  .rt_valid      (rt_valid),
  .flush_valid   (flush_valid),
  .dec_stall     (dec_stall),
  .dec_limited   (dec_limited),
  .dec_stop_stage(dec_stop_stage),
  .rel_mask      (rel_mask),
  .pend_q        (pend_q)
);

// File: tb/creg_scoreboard_tb.sv
module creg_scoreboard_tb;
  logic        clk;
  logic        rst_n;
  logic        dec_valid;
  logic [7:0]  dec_rd_mask;
  logic [31:0] dec_rd_stage;
  logic        dec_wr_en;
  logic [2:0]  dec_wr_idx;
  logic        rt_valid;
  logic [2:0]  rt_idx;
  logic        flush_valid;
  logic [7:0]  flush_mask;
  logic        dec_stall;
  logic        dec_limited;
  logic [3:0]  dec_stop_stage;
  logic [7:0]  rel_mask;

  typedef struct {
    logic       stall;
    logic       limited;
    logic [3:0] stage;
    logic [7:0] rel;
    string      tag;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] model_pend;
  int         checks;
  int         failures;
  bit         finished;

  creg_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_rd_mask(dec_rd_mask),
    .dec_rd_stage(dec_rd_stage), .dec_wr_en(dec_wr_en), .dec_wr_idx(dec_wr_idx),
    .rt_valid(rt_valid), .rt_idx(rt_idx), .flush_valid(flush_valid),
    .flush_mask(flush_mask), .dec_stall(dec_stall), .dec_limited(dec_limited),
    .dec_stop_stage(dec_stop_stage), .rel_mask(rel_mask)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic step(input logic v, input logic [7:0] m, input logic [31:0] s,
                      input logic w, input logic [2:0] wi, input logic r,
                      input logic [2:0] ri, input logic f, input logic [7:0] fm,
                      input string tag);
    exp_t       e;
    logic [7:0] clr;
    logic [7:0] eff;
    logic [7:0] setm;
    @(negedge clk);
    dec_valid = v; dec_rd_mask = m; dec_rd_stage = s; dec_wr_en = w;
    dec_wr_idx = wi; rt_valid = r; rt_idx = ri; flush_valid = f; flush_mask = fm;
    clr  = (r ? (8'h01 << ri) : 8'h00) | (f ? fm : 8'h00);
    eff  = model_pend & ~clr;
    e.tag     = tag;
    e.stall   = v && w && eff[wi];
    e.limited = 1'b0;
    e.stage   = 4'hF;
    if (v && !e.stall) begin
      for (int i = 0; i < 8; i++) begin
        if (m[i] && eff[i]) begin
          e.limited = 1'b1;
          if (s[i*4 +: 4] < e.stage) e.stage = s[i*4 +: 4];
        end
      end
    end
    e.rel = r ? (model_pend & (8'h01 << ri)) : 8'h00;
    setm  = (v && w && !e.stall) ? (8'h01 << wi) : 8'h00;
    model_pend = eff | setm;
    exp_q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        cmp(e.tag, "stall", int'(dec_stall), int'(e.stall));
        cmp(e.tag, "limited", int'(dec_limited), int'(e.limited));
        cmp(e.tag, "stop_stage", int'(dec_stop_stage), int'(e.stage));
        cmp(e.tag, "rel_mask", int'(rel_mask), int'(e.rel));
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; finished = 1'b0; model_pend = 8'h00;
    rst_n = 1'b0; dec_valid = 0; dec_rd_mask = 0; dec_rd_stage = 0; dec_wr_en = 0;
    dec_wr_idx = 0; rt_valid = 0; rt_idx = 0; flush_valid = 0; flush_mask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: everything free after reset
    step(1, 8'hFF, 32'h7654_3210, 0, 0, 0, 0, 0, 8'h00, "R1");
    // R2: accept write to reg 3
    step(1, 8'h00, 32'h0, 1, 3'd3, 0, 0, 0, 8'h00, "R2");
    // R3: read of pending reg 3 at stage 5
    step(1, 8'h08, 32'h0000_5000, 0, 0, 0, 0, 0, 8'h00, "R3");
    // R4: read of a non-pending reg only
    step(1, 8'h04, 32'h0000_0900, 0, 0, 0, 0, 0, 8'h00, "R4");
    // R5: WAW on reg 3 stalls, even with a read present
    step(1, 8'h08, 32'h0000_2000, 1, 3'd3, 0, 0, 0, 8'h00, "R5");
    // R2: write reg 5
    step(1, 8'h00, 32'h0, 1, 3'd5, 0, 0, 0, 8'h00, "R2");
    // R6: regs 1,3,5 read at 0,7,2; only 3 and 5 pending -> 2
    step(1, 8'h2A, 32'h0020_7000, 0, 0, 0, 0, 0, 8'h00, "R6");
    step(1, 8'h28, 32'h00C0_4000, 0, 0, 0, 0, 0, 8'h00, "R6");
    // R7/R8: retire reg 3 with a read of reg 3 in the same cycle
    step(1, 8'h08, 32'h0000_6000, 0, 0, 1, 3'd3, 0, 8'h00, "R7");
    step(1, 8'h08, 32'h0000_6000, 0, 0, 0, 0, 0, 8'h00, "R7");
    // R9/R8: flush reg 5, same-cycle read of reg 5 is free
    step(1, 8'h20, 32'h0030_0000, 0, 0, 0, 0, 1, 8'h20, "R9");
    step(1, 8'h20, 32'h0030_0000, 0, 0, 0, 0, 0, 8'h00, "R9");
    // R10: retire non-pending reg 6
    step(1, 8'h00, 32'h0, 0, 0, 1, 3'd6, 0, 8'h00, "R10");
    step(1, 8'h40, 32'h0100_0000, 0, 0, 0, 0, 0, 8'h00, "R10");
    // R11: pend reg 2, then rewrite it in the flush cycle
    step(1, 8'h00, 32'h0, 1, 3'd2, 0, 0, 0, 8'h00, "R11");
    step(1, 8'h00, 32'h0, 1, 3'd2, 0, 0, 1, 8'h04, "R11");
    step(1, 8'h04, 32'h0000_0A00, 0, 0, 0, 0, 0, 8'h00, "R11");
    // R11: rewrite reg 2 in its retire cycle
    step(1, 8'h00, 32'h0, 1, 3'd2, 1, 3'd2, 0, 8'h00, "R11");
    step(1, 8'h04, 32'h0000_0100, 0, 0, 0, 0, 0, 8'h00, "R11");
    // R12: no valid -> no stall, no set of reg 7
    step(0, 8'h04, 32'h0000_0100, 1, 3'd2, 0, 0, 0, 8'h00, "R12");
    step(0, 8'h00, 32'h0, 1, 3'd7, 0, 0, 0, 8'h00, "R12");
    step(1, 8'h80, 32'h3000_0000, 0, 0, 0, 0, 0, 8'h00, "R12");
    // R3: stage 0 and 15 edge values on pending reg 2
    step(1, 8'h04, 32'h0000_0000, 0, 0, 0, 0, 0, 8'h00, "R3");
    step(1, 8'h04, 32'h0000_0F00, 0, 0, 0, 0, 0, 8'h00, "R3");
    step(0, 8'h00, 32'h0, 0, 0, 0, 0, 0, 8'h00, "idle");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule